// File: doc/BRIEF.md
# Fixed-Latency Handshaked Compute Wrapper

The block places a short pipelined arithmetic datapath behind a valid/ready handshake. Each accepted word `d` gives the result `(d + ADD_K) * MUL_K`, truncated to `DATA_W` bits. An upstream producer presents words on the `up_*` side, and a downstream consumer takes results on the `dn_*` side. `up_ready_o` is the block's own ready toward the producer. `dn_ready_i` is the consumer's ready toward the block.

The `MODE` parameter selects one of two variants when the block is built. In stall-free mode the pipeline advances on every clock and the block never pushes back. A result leaves exactly `LATENCY` cycles after its word was accepted, and the downstream ready is not looked at. In stallable mode the block honours downstream backpressure. Results that cannot leave are held in an output FIFO of `LATENCY+1` entries. An occupancy counter lowers `up_ready_o` before that storage could overflow. In this mode `LATENCY` (at least 1) is a minimum delay and not a promise.

Top module: `fixlat_wrap`

## Requirements
- R1: While `rst_ni` is low, `dn_valid_o` is low. After reset is released, `up_ready_o` is high and no result is pending.
- R2: Every delivered result equals `(d + ADD_K) * MUL_K` modulo 2^`DATA_W`, where `d` is the accepted word.
- R3: In stall-free mode, a word transferred in cycle k is shown with `dn_valid_o` high in cycle k+`LATENCY`, and in no other cycle.
- R4: In stall-free mode, `up_ready_o` stays high, so words can be accepted on consecutive cycles at one word per cycle.
- R5: In stall-free mode, `dn_ready_i` has no effect: results appear and retire on schedule whatever its value.
- R6: A word is taken only in a cycle where `up_valid_i` and `up_ready_o` are both high. A word held valid while `up_ready_o` is low is taken exactly once.
- R7: In stallable mode, a result retires only when `dn_valid_o` and `dn_ready_i` are both high. While `dn_valid_o` is high and `dn_ready_i` is low, `dn_valid_o` stays high and `dn_data_o` does not change in the next cycle.
- R8: In stallable mode, no result appears earlier than `LATENCY` cycles after its word was accepted. With `dn_ready_i` held high and no stored results, the delay is exactly `LATENCY`.
- R9: In stallable mode, the number of accepted but not yet retired words never exceeds `LATENCY+1`, and `up_ready_o` is low while it equals `LATENCY+1`. Results retire in acceptance order, with none lost and none repeated.
- R10: In stallable mode, when `dn_ready_i` is held high, `up_ready_o` stays high under back-to-back input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Producer has a word |
| up_data_i | input | DATA_W | Producer word |
| up_ready_o | output | 1 | Block can accept a word |
| dn_valid_o | output | 1 | Result available |
| dn_data_o | output | DATA_W | Result word |
| dn_ready_i | input | 1 | Consumer can take a result |

## Verification
The bench drives two instances side by side, one stallable and one stall-free, and tries each with several input patterns. Sparse words sent one every 16 cycles isolate the exact input-to-output delay. Back-to-back bursts show full throughput and that `up_ready_o` stays high. Random gaps combined with random or mostly-low downstream ready expose reordering, loss, duplication and unstable held outputs. A directed case holds the consumer off until the stallable block fills. It checks that `up_ready_o` drops at exactly `LATENCY+1` pending words and that a word held on the input is not taken until space returns.

// File: rtl/fixlat_pkg.sv
package fixlat_pkg;

  typedef enum logic {
    LW_STALLABLE  = 1'b0,
    LW_STALL_FREE = 1'b1
  } lw_mode_e;

  // counter width able to hold 0..n
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fixlat_pipe.sv
module fixlat_pipe #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LATENCY = 4,
  parameter logic [DATA_W-1:0] ADD_K = 'h35,
  parameter logic [DATA_W-1:0] MUL_K = 'h0b
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_v_i,
  input  logic [DATA_W-1:0] in_d_i,
  output logic              out_v_o,
  output logic [DATA_W-1:0] out_d_o
);

  logic [LATENCY-1:0] v_q;
  logic [DATA_W-1:0]  d_q   [LATENCY];
  logic [DATA_W-1:0]  nxt_d [LATENCY];

  // stage 0 adds, stage 1 multiplies, later stages only delay
  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    if (s == 0) begin : g_head
      if (LATENCY == 1) begin : g_fused
        assign nxt_d[s] = (in_d_i + ADD_K) * MUL_K;
      end else begin : g_add
        assign nxt_d[s] = in_d_i + ADD_K;
      end
    end else if (s == 1) begin : g_mul
      assign nxt_d[s] = d_q[0] * MUL_K;
    end else begin : g_dly
      assign nxt_d[s] = d_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < LATENCY; i++) d_q[i] <= '0;
    end else begin
      v_q[0] <= in_v_i;
      d_q[0] <= nxt_d[0];
      for (int i = 1; i < LATENCY; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= nxt_d[i];
      end
    end
  end

  assign out_v_o = v_q[LATENCY-1];
  assign out_d_o = d_q[LATENCY-1];

endmodule

// File: rtl/fixlat_fifo.sv
module fixlat_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = fixlat_pkg::cnt_width(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/fixlat_credit.sv
module fixlat_credit #(
  parameter int unsigned DEPTH = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic room_o
);

  localparam int unsigned CNT_W = fixlat_pkg::cnt_width(DEPTH);

  logic [CNT_W-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= used_q + CNT_W'(take_i) - CNT_W'(give_i);
  end

  assign room_o = (used_q < CNT_W'(DEPTH));

endmodule

// File: rtl/fixlat_wrap.sv
module fixlat_wrap
  import fixlat_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LATENCY = 4,
  parameter lw_mode_e    MODE    = LW_STALLABLE,
  parameter logic [DATA_W-1:0] ADD_K = 'h35,
  parameter logic [DATA_W-1:0] MUL_K = 'h0b
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_ready_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o,
  input  logic              dn_ready_i
);

  localparam int unsigned DEPTH = LATENCY + 1;

  logic              up_fire;
  logic              pipe_v;
  logic [DATA_W-1:0] pipe_d;

  assign up_fire = up_valid_i & up_ready_o;

  fixlat_pipe #(
    .DATA_W (DATA_W),
    .LATENCY(LATENCY),
    .ADD_K  (ADD_K),
    .MUL_K  (MUL_K)
  ) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_v_i (up_fire),
    .in_d_i (up_data_i),
    .out_v_o(pipe_v),
    .out_d_o(pipe_d)
  );

  if (MODE == LW_STALL_FREE) begin : g_free
    assign up_ready_o = 1'b1;
    assign dn_valid_o = pipe_v;
    assign dn_data_o  = pipe_d;
  end else begin : g_stall
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_push;
    logic              fifo_pop;
    logic              dn_fire;

    // pipe output bypasses an empty FIFO so the minimum delay stays LATENCY
    assign dn_valid_o = ~fifo_empty | pipe_v;
    assign dn_data_o  = fifo_empty ? pipe_d : fifo_head;
    assign dn_fire    = dn_valid_o & dn_ready_i;
    assign fifo_push  = pipe_v & ~(fifo_empty & dn_ready_i);
    assign fifo_pop   = ~fifo_empty & dn_ready_i;

    fixlat_fifo #(
      .WIDTH(DATA_W),
      .DEPTH(DEPTH)
    ) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (fifo_push),
      .wdata_i(pipe_d),
      .pop_i  (fifo_pop),
      .rdata_o(fifo_head),
      .empty_o(fifo_empty)
    );

    fixlat_credit #(
      .DEPTH(DEPTH)
    ) u_credit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(up_fire),
      .give_i(dn_fire),
      .room_o(up_ready_o)
    );
  end

endmodule

// File: rtl/fixlat_wrap_chk.sv
module fixlat_wrap_chk
  import fixlat_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LATENCY = 4,
  parameter lw_mode_e    MODE    = LW_STALLABLE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              up_valid_i,
  input logic              up_ready_o,
  input logic              dn_valid_o,
  input logic [DATA_W-1:0] dn_data_o,
  input logic              dn_ready_i
);

  localparam int unsigned DEPTH = LATENCY + 1;
  localparam int unsigned OCC_W = cnt_width(DEPTH + 1);
  localparam bit          STALL = (MODE == LW_STALLABLE);

  logic             up_f, dn_f;
  logic [OCC_W-1:0] occ_q;

  assign up_f = up_valid_i & up_ready_o;
  assign dn_f = dn_valid_o & (dn_ready_i | ~STALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + OCC_W'(up_f) - OCC_W'(dn_f);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R1
      rst_chk: assert (!dn_valid_o) else $error("dn_valid_o high in reset");
    end
  end

  // R8
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (occ_q != '0));

  // R9
  cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH));

  // R9
  full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STALL && occ_q >= OCC_W'(DEPTH)) |-> !up_ready_o);

  // R10
  room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q < OCC_W'(DEPTH)) |-> up_ready_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (STALL && dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_data_o)));

endmodule

bind fixlat_wrap fixlat_wrap_chk #(
  .DATA_W (DATA_W),
  .LATENCY(LATENCY),
  .MODE   (MODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_valid_i(up_valid_i),
  .up_ready_o(up_ready_o),
  .dn_valid_o(dn_valid_o),
  .dn_data_o (dn_data_o),
  .dn_ready_i(dn_ready_i)
);

// File: tb/tb_fixlat_wrap.sv
module tb_fixlat_wrap;
  import fixlat_pkg::*;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW    = 16;
  localparam int unsigned N_S   = 4;
  localparam int unsigned N_F   = 3;
  localparam logic [DW-1:0] ADD_K = 16'h0035;
  localparam logic [DW-1:0] MUL_K = 16'h000b;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          s_uv = 1'b0, s_ur, s_dv, s_dr = 1'b1;
  logic [DW-1:0] s_ud = '0, s_dd;
  logic          f_uv = 1'b0, f_ur, f_dv, f_dr = 1'b0;
  logic [DW-1:0] f_ud = '0, f_dd;

  fixlat_wrap #(.DATA_W(DW), .LATENCY(N_S), .MODE(LW_STALLABLE),
                .ADD_K(ADD_K), .MUL_K(MUL_K)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .up_valid_i(s_uv), .up_data_i(s_ud),
    .up_ready_o(s_ur), .dn_valid_o(s_dv), .dn_data_o(s_dd), .dn_ready_i(s_dr));

  fixlat_wrap #(.DATA_W(DW), .LATENCY(N_F), .MODE(LW_STALL_FREE),
                .ADD_K(ADD_K), .MUL_K(MUL_K)) dut_sf (
    .clk_i(clk), .rst_ni(rst_ni), .up_valid_i(f_uv), .up_data_i(f_ud),
    .up_ready_o(f_ur), .dn_valid_o(f_dv), .dn_data_o(f_dd), .dn_ready_i(f_dr));

  int unsigned n_chk = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] s_exp_q[$], f_exp_q[$];
  int unsigned   s_tin_q[$], f_tin_q[$];
  bit s_exact = 0, s_b2b = 0, in_reset = 1;
  int unsigned s_rdy_mode = 0;
  bit s_prev_stall = 0;
  logic [DW-1:0] s_prev_d = '0;

  function automatic logic [DW-1:0] ref_f(logic [DW-1:0] d);
    logic [DW-1:0] s;
    s = d + ADD_K;
    return s * MUL_K;
  endfunction

  task automatic chk(bit ok, string req, string what, int unsigned act, int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (in_reset) begin
      // R1
      chk(!s_dv, "R1", "stallable dn_valid in reset", s_dv, 0);
      chk(!f_dv, "R1", "stall-free dn_valid in reset", f_dv, 0);
    end else begin
      // stallable instance
      if (s_prev_stall) begin
        chk(s_dv, "R7", "valid dropped while stalled", s_dv, 1);
        chk(s_dd == s_prev_d, "R7", "data changed while stalled", s_dd, s_prev_d);
      end
      if (s_b2b) chk(s_ur, "R10", "up_ready low under full downstream", s_ur, 1);
      if (s_uv && s_ur) begin
        s_exp_q.push_back(ref_f(s_ud));
        s_tin_q.push_back(cyc);
      end
      if (s_dv && s_dr) begin
        if (s_exp_q.size() == 0) begin
          chk(0, "R9", "extra result", s_dd, 0);
        end else begin
          logic [DW-1:0] e;
          int unsigned t;
          e = s_exp_q.pop_front();
          t = s_tin_q.pop_front();
          chk(s_dd == e, "R2/R9", "stallable result", s_dd, e);
          if (s_exact) chk(cyc - t == N_S, "R8", "exact delay", cyc - t, N_S);
          else         chk(cyc - t >= N_S, "R8", "minimum delay", cyc - t, N_S);
        end
      end
      s_prev_stall = s_dv && !s_dr;
      s_prev_d     = s_dd;

      // stall-free instance
      chk(f_ur, "R4", "stall-free up_ready", f_ur, 1);
      if (f_uv && f_ur) begin
        f_exp_q.push_back(ref_f(f_ud));
        f_tin_q.push_back(cyc);
      end
      if (f_dv) begin
        if (f_exp_q.size() == 0) begin
          chk(0, "R3", "stall-free spurious valid", f_dd, 0);
        end else begin
          logic [DW-1:0] e;
          int unsigned t;
          e = f_exp_q.pop_front();
          t = f_tin_q.pop_front();
          chk(f_dd == e, "R2", "stall-free result", f_dd, e);
          chk(cyc - t == N_F, "R3/R5", "stall-free delay", cyc - t, N_F);
        end
      end else if (f_tin_q.size() != 0 && cyc - f_tin_q[0] >= N_F) begin
        chk(0, "R3", "stall-free result missing", 0, 1);
        void'(f_exp_q.pop_front());
        void'(f_tin_q.pop_front());
      end
    end
  end

  // downstream ready drivers
  initial begin
    forever begin
      @(posedge clk); #1;
      case (s_rdy_mode)
        0: s_dr = 1'b1;
        1: s_dr = 1'($urandom % 2);
        2: s_dr = ($urandom % 4) == 0;
        default: s_dr = 1'b0;
      endcase
      f_dr = 1'($urandom % 2); // R5: random, must not matter
    end
  end

  task automatic send_s(input logic [DW-1:0] d, input int unsigned gap);
    repeat (gap) begin @(posedge clk); #1; end
    s_uv = 1'b1;
    s_ud = d;
    forever begin
      bit ok;
      @(negedge clk);
      ok = s_ur;
      @(posedge clk); #1;
      if (ok) break;
    end
    s_uv = 1'b0;
    s_ud = DW'($urandom);
  endtask

  task automatic send_f(input logic [DW-1:0] d, input int unsigned gap);
    repeat (gap) begin @(posedge clk); #1; end
    f_uv = 1'b1;
    f_ud = d;
    forever begin
      bit ok;
      @(negedge clk);
      ok = f_ur;
      @(posedge clk); #1;
      if (ok) break;
    end
    f_uv = 1'b0;
    f_ud = DW'($urandom);
  endtask

  task automatic drain_s();
    s_rdy_mode = 0;
    while (s_exp_q.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic run_stallable();
    // sparse words, exact delay
    s_exact = 1;
    for (int i = 0; i < 8; i++) send_s(DW'($urandom), 16);
    drain_s();
    // back-to-back with full downstream
    s_b2b = 1;
    for (int i = 0; i < 30; i++) send_s(DW'($urandom), 0);
    s_b2b = 0;
    drain_s();
    s_exact = 0;
    send_s(16'hffff, 2);
    send_s(16'h0000, 0);
    drain_s();
    // fill with downstream held off
    s_rdy_mode = 3;
    repeat (2) begin @(posedge clk); #1; end
    for (int i = 0; i < N_S + 1; i++) send_s(DW'(16'h0100 + i), 0);
    s_uv = 1'b1;
    s_ud = 16'hbeef;
    repeat (6) begin
      @(negedge clk); #2;
      chk(!s_ur, "R9", "up_ready when full", s_ur, 0);
      chk(s_exp_q.size() == N_S + 1, "R6", "words taken while full", s_exp_q.size(), N_S + 1);
    end
    @(posedge clk); #1;
    s_rdy_mode = 0;
    forever begin
      bit ok;
      @(negedge clk);
      ok = s_ur;
      @(posedge clk); #1;
      if (ok) break;
    end
    s_uv = 1'b0;
    @(negedge clk); #2;
    chk(s_exp_q.size() <= N_S + 1, "R6", "held word taken once", s_exp_q.size(), N_S + 1);
    drain_s();
    // random gaps, random downstream
    s_rdy_mode = 1;
    for (int i = 0; i < 200; i++) send_s(DW'($urandom), $urandom % 4);
    // sparse words, mostly stalled downstream
    s_rdy_mode = 2;
    for (int i = 0; i < 20; i++) send_s(DW'($urandom), 16);
    for (int i = 0; i < 30; i++) send_s(DW'($urandom), 0);
    drain_s();
    chk(s_exp_q.size() == 0, "R9", "results left undelivered", s_exp_q.size(), 0);
  endtask

  task automatic run_free();
    for (int i = 0; i < 10; i++) send_f(DW'($urandom), 16);
    for (int i = 0; i < 40; i++) send_f(DW'($urandom), 0);
    send_f(16'hffcb, 0);
    for (int i = 0; i < 150; i++) send_f(DW'($urandom), $urandom % 3);
    repeat (N_F + 4) @(posedge clk);
    #1;
    chk(f_exp_q.size() == 0, "R3", "stall-free results pending", f_exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    in_reset = 0;
    @(negedge clk); #2;
    chk(s_ur, "R1", "stallable up_ready after reset", s_ur, 1);
    chk(f_ur, "R1", "stall-free up_ready after reset", f_ur, 1);
    chk(!s_dv && !f_dv, "R1", "valid after reset", {s_dv, f_dv}, 0);
    @(posedge clk); #1;
    fork
      run_stallable();
      run_free();
    join
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule